// File: doc/BRIEF.md
# Descriptor-Chained Frame Capture DMA

This block moves pixel beats from a capture stream into memory by following a linked list of descriptors that software builds in memory. Every descriptor is four 32-bit words. It holds the address of the next descriptor, a source word that is not used, a target address, and a command word that carries a byte count and an end-interrupt enable. The engine reads each descriptor through a one-cycle-latency read port. It then writes 64-bit beats from the stream to the target address, in order. After that it moves on to the descriptor named by the next-address word.

Each video buffer ends in one tail descriptor. A finisher tail holds the reserved stop address and usually asks for an interrupt. A linker tail has a zero command and points at the first descriptor of the next buffer. Software can grow the chain while the engine runs by rewriting the last finisher into a linker. If the engine has already taken the stop value, it stays halted. Its status then shows that the channel is stopped, so software can load a new start address, set the run bit again, and restart capture. A transfer never begins straight away: the engine waits for the first end-of-frame beat after capture is enabled, so that every buffer starts on a frame boundary.

Top module: `frame_chain_dma`

## Requirements
- R1: A descriptor at address D is read as four consecutive words at D, D+4, D+8 and D+12, each returned one cycle after its request. Word 0 is the next address, word 1 is ignored, word 2 is the target, word 3 is the command. In the command, bits [12:0] are the byte count and bit 21 is the end-interrupt enable.
- R2: A stream beat moves only in a cycle where pix_valid and pix_ready are both high. In that same cycle it is written to wr_addr, which starts at the target with its low three bits cleared and then advances by 8 per beat. pix_ready is high only while the current descriptor still has beats to move.
- R3: A descriptor moves (byte count >> 3) beats, so the low three count bits are ignored. A descriptor whose beat count is zero moves no data. A linker (command 0) raises no interrupt and sends the fetch on to its next address.
- R4: When a descriptor completes and its next address is not the stop value (1), the engine fetches from that address. When the next address is the stop value, the channel halts: running falls, cur_desc reads 1, and capturing falls.
- R5: Completing a descriptor whose enable bit 21 is set makes irq high from the following cycle. irq stays high until irq_clr is applied, and a completion in the same cycle as irq_clr leaves irq set.
- R6: No descriptor read and no data beat happen until run_set has been applied and, after cap_start, a beat with pix_valid and pix_eof both high has been seen.
- R7: cfg_we loads cfg_addr into cur_desc only while the channel is stopped, and is ignored while it runs. run_set starts the fetch from cur_desc.
- R8: If a finisher is rewritten into a linker before the engine fetches it, the chain runs on into the next buffer. If it is rewritten after the halt, the channel stays halted with no writes until it is reloaded and restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load cfg_addr into the descriptor register (honoured only when stopped) |
| cfg_addr | input | 32 | Start descriptor address |
| run_set | input | 1 | Pulse: set the run bit |
| cap_start | input | 1 | Pulse: enable capture |
| irq_clr | input | 1 | Clear the end-interrupt status |
| pix_valid | input | 1 | Stream beat valid |
| pix_eof | input | 1 | Beat is the last of a frame |
| pix_data | input | 64 | Stream beat data |
| pix_ready | output | 1 | Engine takes a beat this cycle |
| rd_en | output | 1 | Descriptor word read request |
| rd_addr | output | 32 | Descriptor word address |
| rd_data | input | 32 | Read data, one cycle after rd_en |
| wr_en | output | 1 | Beat write strobe |
| wr_addr | output | 32 | Beat write address |
| wr_data | output | 64 | Beat write data |
| cur_desc | output | 32 | Current descriptor address, or the stop value when halted |
| running | output | 1 | Run bit |
| capturing | output | 1 | Capture enabled |
| irq | output | 1 | End interrupt |

## Verification
A beat write is due in the same cycle as its handshake, so every clock the bench compares wr_addr and wr_data with the head of an expected-address queue at the falling edge. Descriptor reads are also compared each cycle against an expected-address queue, so their order is fixed while their exact cycle is free. The interrupt and halt state lag the completing beat or tail fetch by one edge. For these the bench polls running for the halt and samples status only after it. The one-cycle life of irq under a held clear is counted cycle by cycle.

// File: rtl/frame_chain_dma_pkg.sv
package frame_chain_dma_pkg;
   typedef enum logic [1:0] {
      CH_IDLE  = 2'd0,
      CH_FETCH = 2'd1,
      CH_XFER  = 2'd2
   } ch_state_e;

   localparam int DESC_WORDS = 4;
endpackage

// File: rtl/fcd_fetch.sv
module fcd_fetch
   import frame_chain_dma_pkg::*;
#(
   parameter int AW    = 32,
   parameter int LEN_W = 13,
   parameter int IRQ_BIT = 21
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [AW-1:0] go_addr,
   output logic          rd_en,
   output logic [AW-1:0] rd_addr,
   input  logic [31:0]   rd_data,
   output logic          desc_valid,
   output logic [AW-1:0] d_next,
   output logic [AW-1:0] d_tgt,
   output logic [LEN_W-1:0] d_len,
   output logic          d_irq
);
   localparam int NW    = DESC_WORDS;
   localparam int IDX_W = $clog2(NW);

   logic             busy;
   logic [IDX_W-1:0] idx;
   logic [AW-1:0]    base;
   logic             cap_vld;
   logic [IDX_W-1:0] cap_idx;
   logic [31:0]      word_q [NW];
   logic             unused_bits;

   if (NW != 4) begin : g_bad_nw
      $error("descriptor must be four words");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         idx  <= '0;
         base <= '0;
      end else if (go) begin
         busy <= 1'b1;
         idx  <= '0;
         base <= go_addr;
      end else if (busy) begin
         if (idx == IDX_W'(NW - 1)) busy <= 1'b0;
         idx <= idx + 1'b1;
      end
   end

   assign rd_en   = busy;
   assign rd_addr = base + (AW'(idx) << 2);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_vld    <= 1'b0;
         cap_idx    <= '0;
         desc_valid <= 1'b0;
         for (int w = 0; w < NW; w++) word_q[w] <= '0;
      end else begin
         cap_vld    <= rd_en;
         cap_idx    <= idx;
         desc_valid <= cap_vld && (cap_idx == IDX_W'(NW - 1));
         for (int w = 0; w < NW; w++)
            if (cap_vld && cap_idx == IDX_W'(w)) word_q[w] <= rd_data;
      end
   end

   assign d_next = word_q[0][AW-1:0];
   assign d_tgt  = word_q[2][AW-1:0];
   assign d_len  = word_q[3][LEN_W-1:0];
   assign d_irq  = word_q[3][IRQ_BIT];
   assign unused_bits = ^{word_q[0], word_q[1], word_q[2], word_q[3]};

   AST_FETCH_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && idx != '0) |-> rd_addr == $past(rd_addr) + AW'(4)); // R1
   AST_FETCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid |-> !rd_en); // R1
endmodule

// File: rtl/fcd_mover.sv
module fcd_mover #(
   parameter int AW    = 32,
   parameter int DW    = 64,
   parameter int LEN_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [AW-1:0]    ld_tgt,
   input  logic [LEN_W-1:0] ld_beats,
   input  logic             pix_valid,
   input  logic [DW-1:0]    pix_data,
   output logic             pix_ready,
   output logic             wr_en,
   output logic [AW-1:0]    wr_addr,
   output logic [DW-1:0]    wr_data,
   output logic             done
);
   localparam int BEAT_B = DW / 8;
   localparam int ALIGN  = $clog2(BEAT_B);

   logic [AW-1:0]    tgt;
   logic [LEN_W-1:0] left;
   logic             take;
   logic             unused_low;

   if ((1 << ALIGN) != BEAT_B || ALIGN < 1) begin : g_bad_dw
      $error("beat width must be a power-of-two number of bytes, at least two");
   end

   assign pix_ready  = (left != '0);
   assign take       = pix_valid && pix_ready;
   assign wr_en      = take;
   assign wr_addr    = tgt;
   assign wr_data    = pix_data;
   assign done       = take && (left == LEN_W'(1));
   assign unused_low = ^ld_tgt[ALIGN-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tgt  <= '0;
         left <= '0;
      end else if (load) begin
         tgt  <= {ld_tgt[AW-1:ALIGN], {ALIGN{1'b0}}};
         left <= ld_beats;
      end else if (take) begin
         tgt  <= tgt + AW'(BEAT_B);
         left <= left - 1'b1;
      end
   end

   AST_WR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> wr_addr[ALIGN-1:0] == '0); // R2
   AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !pix_ready); // R2
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !done) |=> wr_addr == $past(wr_addr) + AW'(BEAT_B)); // R2
endmodule

// File: rtl/fcd_irq.sv
module fcd_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic irq
);
   always_ff @(posedge clk) begin
      if (!rst_n)   irq <= 1'b0;
      else if (set) irq <= 1'b1;
      else if (clr) irq <= 1'b0;
   end

   AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> irq); // R5
   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !clr) |=> irq); // R5
endmodule

// File: rtl/frame_chain_dma.sv
module frame_chain_dma
   import frame_chain_dma_pkg::*;
#(
   parameter int AW      = 32,
   parameter int DW      = 64,
   parameter int LEN_W   = 13,
   parameter int IRQ_BIT = 21,
   parameter logic [AW-1:0] STOP_ADDR = AW'(1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [AW-1:0] cfg_addr,
   input  logic          run_set,
   input  logic          cap_start,
   input  logic          irq_clr,
   input  logic          pix_valid,
   input  logic          pix_eof,
   input  logic [DW-1:0] pix_data,
   output logic          pix_ready,
   output logic          rd_en,
   output logic [AW-1:0] rd_addr,
   input  logic [31:0]   rd_data,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic [DW-1:0] wr_data,
   output logic [AW-1:0] cur_desc,
   output logic          running,
   output logic          capturing,
   output logic          irq
);
   localparam int ALIGN = $clog2(DW / 8);

   if (AW < 8 || AW > 32) begin : g_bad_aw
      $error("address width must be 8..32");
   end
   if (LEN_W <= ALIGN || LEN_W > IRQ_BIT || IRQ_BIT > 31) begin : g_bad_cmd
      $error("command field layout is inconsistent");
   end

   ch_state_e        st;
   logic             run_q, cap_q, sync_q;
   logic [AW-1:0]    desc_q, next_hold;
   logic             irq_hold;

   logic             go, desc_valid, d_irq, mv_done, mv_load;
   logic [AW-1:0]    go_addr, d_next, d_tgt;
   logic [LEN_W-1:0] d_len, d_beats;
   logic             zero_desc, complete, halt, comp_irq;
   logic [AW-1:0]    comp_next;

   fcd_fetch #(.AW(AW), .LEN_W(LEN_W), .IRQ_BIT(IRQ_BIT)) u_fetch (
      .clk(clk), .rst_n(rst_n), .go(go), .go_addr(go_addr),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .desc_valid(desc_valid), .d_next(d_next), .d_tgt(d_tgt),
      .d_len(d_len), .d_irq(d_irq)
   );

   assign d_beats = d_len >> ALIGN;

   always_comb begin
      zero_desc = (st == CH_FETCH) && desc_valid && (d_beats == '0);
      mv_load   = (st == CH_FETCH) && desc_valid && (d_beats != '0);
      complete  = zero_desc || ((st == CH_XFER) && mv_done);
      comp_irq  = zero_desc ? d_irq  : irq_hold;
      comp_next = zero_desc ? d_next : next_hold;
      halt      = complete && (comp_next == STOP_ADDR);
      go        = ((st == CH_IDLE) && run_q && sync_q) || (complete && !halt);
      go_addr   = complete ? comp_next : desc_q;
   end

   fcd_mover #(.AW(AW), .DW(DW), .LEN_W(LEN_W)) u_mover (
      .clk(clk), .rst_n(rst_n), .load(mv_load), .ld_tgt(d_tgt),
      .ld_beats(d_beats), .pix_valid(pix_valid), .pix_data(pix_data),
      .pix_ready(pix_ready), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .done(mv_done)
   );

   fcd_irq u_irq (
      .clk(clk), .rst_n(rst_n), .set(complete && comp_irq),
      .clr(irq_clr), .irq(irq)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= CH_IDLE;
         next_hold <= '0;
         irq_hold  <= 1'b0;
      end else begin
         unique case (st)
            CH_IDLE:  if (go) st <= CH_FETCH;
            CH_FETCH: if (mv_load) begin
                         st        <= CH_XFER;
                         next_hold <= d_next;
                         irq_hold  <= d_irq;
                      end else if (halt) st <= CH_IDLE;
            CH_XFER:  if (halt) st <= CH_IDLE;
                      else if (complete) st <= CH_FETCH;
            default:  st <= CH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         cap_q  <= 1'b0;
         sync_q <= 1'b0;
         desc_q <= '0;
      end else begin
         if (halt)         run_q <= 1'b0;
         else if (run_set) run_q <= 1'b1;

         if (cap_start)    cap_q <= 1'b1;
         else if (halt)    cap_q <= 1'b0;

         if (halt) sync_q <= 1'b0;
         else if (cap_q && pix_valid && pix_eof) sync_q <= 1'b1;

         if (complete)              desc_q <= comp_next;
         else if (cfg_we && !run_q) desc_q <= cfg_addr;
      end
   end

   assign cur_desc  = desc_q;
   assign running   = run_q;
   assign capturing = cap_q;

   AST_HALT_SHOWS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run_q) |-> cur_desc == STOP_ADDR); // R4
   AST_NO_READ_UNSYNCED: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (sync_q && run_q)); // R6
   AST_NO_BEAT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> run_q); // R6
   AST_CFG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && run_q && !complete) |=> $stable(cur_desc)); // R7
endmodule

// File: tb/frame_chain_dma_tb.sv
module frame_chain_dma_tb;
   localparam logic [31:0] STOP = 32'h1;
   localparam logic [31:0] IRQB = 32'h0020_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0, run_set = 1'b0, cap_start = 1'b0, irq_clr = 1'b0;
   logic [31:0] cfg_addr = '0;
   logic        pix_valid = 1'b0, pix_eof = 1'b0;
   logic [63:0] pix_data = '0;
   logic        pix_ready, rd_en, wr_en, running, capturing, irq;
   logic [31:0] rd_addr, wr_addr, cur_desc;
   logic [31:0] rd_data = '0;
   logic [63:0] wr_data;

   logic [31:0] mem [256];
   logic [31:0] exp_wq [$];
   logic [31:0] exp_rq [$];
   int          checks = 0, failures = 0, cyc = 0;
   bit          bsync = 1'b0;
   logic [31:0] irq_low_addr = 32'hFFFF_FFFF;
   bit          count_irq = 1'b0;
   int          irq_hi = 0;

   always #10 clk = ~clk;

   frame_chain_dma u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .run_set(run_set), .cap_start(cap_start), .irq_clr(irq_clr),
      .pix_valid(pix_valid), .pix_eof(pix_eof), .pix_data(pix_data),
      .pix_ready(pix_ready), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .cur_desc(cur_desc), .running(running),
      .capturing(capturing), .irq(irq)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rd_en) rd_data <= mem[rd_addr[9:2]];
   end

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Per-clock comparison against the behavioural queues
   always @(negedge clk) begin
      if (rst_n) begin
         if (count_irq && irq) irq_hi++;
         if (wr_en) begin
            chk("R2", "beat address", wr_addr,
                exp_wq.size() > 0 ? exp_wq[0] : 32'hDEAD_BEEF);
            chk("R2", "beat data", wr_data, pix_data);
            if (wr_addr == irq_low_addr) chk("R3", "linker raised irq", irq, 1'b0);
            if (exp_wq.size() > 0) void'(exp_wq.pop_front());
         end
         if (rd_en) begin
            chk("R1", "descriptor word address", rd_addr,
                exp_rq.size() > 0 ? exp_rq[0] : 32'hDEAD_BEEF);
            chk("R6", "read before frame sync", bsync, 1'b1);
            if (exp_rq.size() > 0) void'(exp_rq.pop_front());
         end
      end
   end

   task automatic put_desc(input logic [31:0] a, input logic [31:0] nxt,
                           input logic [31:0] tgt, input logic [31:0] cmd);
      mem[a[9:2]]     = nxt;
      mem[a[9:2] + 1] = 32'h5A5A_0000;
      mem[a[9:2] + 2] = tgt;
      mem[a[9:2] + 3] = cmd;
   endtask

   task automatic exp_fetch(input logic [31:0] a);
      for (int k = 0; k < 4; k++) exp_rq.push_back(a + 32'(4 * k));
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic do_cfg(input logic [31:0] a);
      cfg_addr = a; cfg_we = 1'b1; tick(1); cfg_we = 1'b0;
   endtask

   task automatic do_start();
      run_set = 1'b1; tick(1); run_set = 1'b0;
      cap_start = 1'b1; tick(1); cap_start = 1'b0;
   endtask

   task automatic do_eof();
      bsync = 1'b1;
      pix_valid = 1'b1; pix_eof = 1'b1; pix_data = 64'hE0F;
      tick(1);
      pix_valid = 1'b0; pix_eof = 1'b0;
   endtask

   task automatic stream(input int maxc);
      for (int i = 0; i < maxc; i++) begin
         if (exp_wq.size() == 0) break;
         pix_valid = 1'b1;
         pix_data  = {32'hC0DE_0000, 32'(cyc)};
         tick(1);
      end
      pix_valid = 1'b0;
   endtask

   task automatic wait_halt(input string req);
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (!running) break;
      end
      chk(req, "channel halted", running, 1'b0);
      bsync = 1'b0;
      tick(1);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = '0;
      tick(3);
      rst_n = 1'b1;
      tick(1);
      chk("R6", "reset running", running, 1'b0);
      chk("R6", "reset capturing", capturing, 1'b0);
      chk("R5", "reset irq", irq, 1'b0);
      chk("R2", "reset pix_ready", pix_ready, 1'b0);
      chk("R7", "reset cur_desc", cur_desc, 32'h0);

      // Buffer 1: one 2-beat descriptor, closed by a finisher
      put_desc(32'h100, 32'h110, 32'h1000, 32'd16);
      put_desc(32'h110, STOP, 32'h0, IRQB);
      do_cfg(32'h100);
      chk("R7", "cfg accepted while stopped", cur_desc, 32'h100);
      do_start();
      chk("R7", "run bit set", running, 1'b1);
      chk("R6", "capture enabled", capturing, 1'b1);
      for (int i = 0; i < 10; i++) begin
         pix_valid = 1'b1; pix_data = 64'(i); tick(1);
      end
      pix_valid = 1'b0;
      chk("R6", "no fetch before end of frame", exp_rq.size(), 0);
      chk("R6", "no ready before end of frame", pix_ready, 1'b0);

      exp_fetch(32'h100);
      do_eof();
      tick(12);
      chk("R2", "ready while beats remain", pix_ready, 1'b1);
      chk("R1", "first descriptor fetched", exp_rq.size(), 0);
      do_cfg(32'h300);
      tick(2);
      chk("R7", "cfg ignored while running", cur_desc, 32'h100);

      // Hot append: finisher becomes linker before it is fetched
      put_desc(32'h200, 32'h210, 32'h2004, 32'd20);
      put_desc(32'h210, STOP, 32'h0, IRQB);
      put_desc(32'h110, 32'h200, 32'h0, 32'h0);
      exp_fetch(32'h110); exp_fetch(32'h200); exp_fetch(32'h210);
      exp_wq.push_back(32'h1000); exp_wq.push_back(32'h1008);
      exp_wq.push_back(32'h2000); exp_wq.push_back(32'h2008);
      irq_low_addr = 32'h2000;
      stream(200);
      wait_halt("R4");
      irq_low_addr = 32'hFFFF_FFFF;
      chk("R8", "appended buffer captured", exp_wq.size(), 0);
      chk("R3", "truncated count fetched all", exp_rq.size(), 0);
      chk("R4", "cur_desc reads stop", cur_desc, STOP);
      chk("R4", "capture disabled at halt", capturing, 1'b0);
      chk("R5", "finisher irq", irq, 1'b1);
      tick(20);
      chk("R5", "irq sticky", irq, 1'b1);

      // Link miss: channel halts, rewrite comes too late
      put_desc(32'h300, 32'h310, 32'h3000, 32'd8 | IRQB);
      put_desc(32'h310, STOP, 32'h0, IRQB);
      do_cfg(32'h300);
      chk("R7", "cfg accepted after halt", cur_desc, 32'h300);
      exp_fetch(32'h300); exp_fetch(32'h310);
      exp_wq.push_back(32'h3000);
      do_start();
      do_eof();
      stream(200);
      wait_halt("R4");
      chk("R5", "irq kept with second event pending", irq, 1'b1);
      irq_clr = 1'b1; tick(1); irq_clr = 1'b0;
      tick(1);
      chk("R5", "irq cleared", irq, 1'b0);
      put_desc(32'h310, 32'h400, 32'h0, 32'h0);
      for (int i = 0; i < 20; i++) begin
         pix_valid = 1'b1; pix_data = 64'(i); tick(1);
      end
      pix_valid = 1'b0;
      chk("R8", "late rewrite stays halted", running, 1'b0);
      chk("R8", "late rewrite keeps stop", cur_desc, STOP);

      // Restart from a new start address; irq_clr held throughout
      put_desc(32'h400, 32'h410, 32'h4000, 32'd8 | IRQB);
      put_desc(32'h410, STOP, 32'h0, 32'h0);
      do_cfg(32'h400);
      chk("R8", "restart address loaded", cur_desc, 32'h400);
      exp_fetch(32'h400); exp_fetch(32'h410);
      exp_wq.push_back(32'h4000);
      irq_clr = 1'b1;
      irq_hi = 0;
      count_irq = 1'b1;
      do_start();
      do_eof();
      stream(200);
      wait_halt("R8");
      tick(5);
      count_irq = 1'b0;
      irq_clr = 1'b0;
      chk("R5", "set wins over held clear", irq_hi, 1);
      chk("R8", "restarted buffer captured", exp_wq.size(), 0);
      chk("R1", "restart fetch order", exp_rq.size(), 0);
      chk("R4", "zero-command tail halts", cur_desc, STOP);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      wait (cyc >= 20000);
      failures++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule